// File: doc/BRIEF.md
# Write-Guarded SPI Byte Memory

This block is an SPI-attached byte memory of 1024 locations with a software-controlled write guard. A host drives clock, active-low select and serial input in SPI mode 0 and reads a serial output. Each frame starts with a one-byte command. The commands set or clear a write permission flag, read or write a small status byte, write a run of bytes into one 16-byte page, or stream bytes out from any address.

Every write, whether to the array or to the status byte, needs the permission flag to be set first. The flag clears itself when the resulting write cycle ends. A write cycle is a busy interval of a fixed number of system clocks. During that interval only the status read is honoured, and the top status bit reports the busy state. A three-bit protection code held in the status byte selects one of seven address regions as read-only.

All SPI pins are sampled by the system clock through a synchronizer, and all behaviour is decided on the system clock.

Top module: `spi_guarded_mem`

## Requirements
- R1: After reset, a status read returns 00h, every array byte reads 00h, and the write permission flag is clear.
- R2: Command 06h sets the write permission flag and command 04h clears it. Any other command byte, for example FFh, changes neither the flag nor the memory.
- R3: If the permission flag is clear, command 02h (array write) and command 01h (status write) leave the array and the status byte unchanged.
- R4: The permission flag clears when a write cycle ends, so a second write without a new 06h is ignored.
- R5: Command 01h followed by exactly one data byte and a select release stores data bits 4..3 as the timer-select field (status bits 4..3) and data bits 2..0 as the protection code (status bits 2..0). Status bits 6..5 always read 0. A status write carrying two data bytes is discarded.
- R6: Command 05h returns the status byte and repeats it, refreshed, for every further byte of the frame. Bit 7 is 1 for BUSY_CLKS system clocks after a write is committed and 0 otherwise.
- R7: While bit 7 of the status is 1, every command except 05h is ignored for the rest of its frame, including 06h.
- R8: Command 02h takes a 16-bit address, MSB first, and uses only its low 10 bits. Data bytes then fill consecutive locations, wrapping inside the 16-byte page of the start address, and a later byte overwrites an earlier one. The bytes are committed when select rises after at least one whole data byte.
- R9: An array write whose select rises part-way through a byte commits nothing.
- R10: Protection codes map to read-only ranges: 000 none; 001 000h-0FFh; 010 100h-1FFh; 011 200h-2FFh; 100 300h-3FFh; 101 000h-1FFh; 110 000h-00Fh; 111 3F0h-3FFh. Write bytes that fall inside the selected range are dropped, and the others in the same page are written.
- R11: Protected locations can still be read with command 03h.
- R12: Command 03h takes a 16-bit address and returns bytes from consecutive locations for as long as select stays low, wrapping from 3FFh to 000h.
- R13: Output bits are sent MSB first and change only after a falling SCK edge. The output is 0 while select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data into the block, sampled on rising SCK |
| spi_miso | output | 1 | Serial data out of the block, updated after falling SCK |

## Verification
The two functions that can coincide are a status read and the end of a write cycle. At the clock where the busy interval expires, the busy bit falls and the permission flag clears while the host may be shifting out a status byte. The bench commits a write and then keeps one status-read frame open across the whole busy interval. It judges the result by requiring bit 7 set in the first returned byte and clear in the last one, and by showing that a write issued without a fresh 06h afterwards is ignored. A similar overlap of an incoming command with the busy window is provoked by sending a write, and separately a 06h, immediately after a commit. Neither may take effect.

// File: rtl/spm_pkg.sv
package spm_pkg;

   localparam logic [7:0] CMD_PERMIT   = 8'h06;
   localparam logic [7:0] CMD_REVOKE   = 8'h04;
   localparam logic [7:0] CMD_STAT_WR  = 8'h01;
   localparam logic [7:0] CMD_STAT_RD  = 8'h05;
   localparam logic [7:0] CMD_ARR_WR   = 8'h02;
   localparam logic [7:0] CMD_ARR_RD   = 8'h03;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADDR_HI,
      PH_ADDR_LO,
      PH_WR_DATA,
      PH_RD_DATA,
      PH_ST_DATA,
      PH_ST_STREAM,
      PH_DRAIN
   } spm_phase_e;

endpackage

// File: rtl/spm_sync.sv
module spm_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("spm_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("spm_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/spm_lock_decode.sv
module spm_lock_decode #(
   parameter int ADDR_W = 10,
   parameter int PAGE_W = 4,
   localparam int PIDX_W = ADDR_W - PAGE_W
) (
   input  logic [2:0]        code_i,
   input  logic [PIDX_W-1:0] page_i,
   output logic              locked_o
);

   generate
      if (PIDX_W < 2) begin : g_bad_geom
         $error("spm_lock_decode: need at least four pages");
      end
   endgenerate

   logic [1:0] quarter;
   assign quarter = page_i[PIDX_W-1 -: 2];

   always_comb begin
      unique case (code_i)
         3'd1:    locked_o = (quarter == 2'd0);
         3'd2:    locked_o = (quarter == 2'd1);
         3'd3:    locked_o = (quarter == 2'd2);
         3'd4:    locked_o = (quarter == 2'd3);
         3'd5:    locked_o = !page_i[PIDX_W-1];
         3'd6:    locked_o = (page_i == '0);
         3'd7:    locked_o = (page_i == '1);
         default: locked_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/spm_wr_timer.sv
module spm_wr_timer #(
   parameter int BUSY_CLKS = 1000,
   localparam int CNT_W = $clog2(BUSY_CLKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);

   generate
      if (BUSY_CLKS < 1) begin : g_bad_busy
         $error("spm_wr_timer: BUSY_CLKS must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] left_q;
   logic             busy_q;

   assign busy_o = busy_q;
   assign done_o = busy_q && (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (start_i && !busy_q) begin
         busy_q <= 1'b1;
         left_q <= CNT_W'(BUSY_CLKS - 1);
      end else if (busy_q) begin
         if (left_q == '0) busy_q <= 1'b0;
         else              left_q <= left_q - 1'b1;
      end
   end

   // R6
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && left_q != '0) |=> busy_q);

endmodule

// File: rtl/spm_array.sv
module spm_array #(
   parameter int ADDR_W = 10,
   parameter int PAGE_W = 4,
   localparam int DEPTH      = 1 << ADDR_W,
   localparam int PAGE_BYTES = 1 << PAGE_W,
   localparam int PIDX_W     = ADDR_W - PAGE_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    commit_i,
   input  logic [PIDX_W-1:0]       page_i,
   input  logic [PAGE_BYTES*8-1:0] pbuf_i,
   input  logic [PAGE_BYTES-1:0]   pvalid_i,
   input  logic [2:0]              lock_code_i,
   input  logic [ADDR_W-1:0]       rd_addr_i,
   output logic [7:0]              rd_data_o
);

   logic [7:0] mem_q [DEPTH];
   logic       page_locked;

   spm_lock_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_lock (
      .code_i   (lock_code_i),
      .page_i   (page_i),
      .locked_o (page_locked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < DEPTH; j++) mem_q[j] <= '0;
      end else if (commit_i && !page_locked) begin
         for (int i = 0; i < PAGE_BYTES; i++) begin
            if (pvalid_i[i]) mem_q[{page_i, PAGE_W'(i)}] <= pbuf_i[i*8 +: 8];
         end
      end
   end

   assign rd_data_o = mem_q[rd_addr_i];

   generate
      for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot_chk
         localparam logic [PAGE_W-1:0] SLOT = PAGE_W'(g);
         // R10
         lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (commit_i && page_locked) |=>
               mem_q[{$past(page_i), SLOT}] == $past(mem_q[{page_i, SLOT}]));
         // R8
         slot_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (commit_i && !pvalid_i[g]) |=>
               mem_q[{$past(page_i), SLOT}] == $past(mem_q[{page_i, SLOT}]));
      end
   endgenerate

endmodule

// File: rtl/spi_guarded_mem.sv
module spi_guarded_mem
   import spm_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int PAGE_W      = 4,
   parameter int BUSY_CLKS   = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_cs_n,
   input  logic spi_mosi,
   output logic spi_miso
);

   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int PIDX_W     = ADDR_W - PAGE_W;
   localparam int AHI_W      = ADDR_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("spi_guarded_mem: ADDR_W must be 9..16");
      end
      if (PAGE_W < 1 || PAGE_W > ADDR_W - 2) begin : g_bad_page
         $error("spi_guarded_mem: PAGE_W out of range");
      end
   endgenerate

   // pin synchronizer and edge detection
   logic [2:0] pins_s;
   logic       sck_s, csn_s, mosi_s, sck_d_q, csn_d_q;
   logic       sck_rise, sck_fall, cs_rise, cs_act;

   spm_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({spi_sck, spi_cs_n, spi_mosi}),
      .q_o   (pins_s)
   );

   assign {sck_s, csn_s, mosi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d_q <= 1'b0;
         csn_d_q <= 1'b1;
      end else begin
         sck_d_q <= sck_s;
         csn_d_q <= csn_s;
      end
   end

   assign cs_act   = !csn_s;
   assign cs_rise  = csn_s && !csn_d_q;
   assign sck_rise = sck_s && !sck_d_q;
   assign sck_fall = !sck_s && sck_d_q;

   // frame state
   spm_phase_e              phase_q;
   logic [2:0]              bit_q;
   logic [7:0]              rx_q;
   logic                    is_rd_q;
   logic                    got_q;
   logic [AHI_W-1:0]        ahi_q;
   logic [ADDR_W-1:0]       ptr_q;
   logic [PIDX_W-1:0]       page_q;
   logic [PAGE_W-1:0]       slot_q;
   logic [PAGE_BYTES*8-1:0] pbuf_q;
   logic [PAGE_BYTES-1:0]   pvalid_q;
   logic [4:0]              sdat_q;
   logic [1:0]              tsel_q;
   logic [2:0]              lock_q;
   logic                    wel_q;
   logic [7:0]              tx_q;
   logic                    so_q;

   logic [7:0]        rx_byte;
   logic              byte_done;
   logic [ADDR_W-1:0] addr_now;
   logic [ADDR_W-1:0] rd_addr;
   logic [7:0]        rd_data;
   logic [7:0]        status_w;
   logic              busy, tmr_done;
   logic              wr_commit, st_commit;

   assign rx_byte   = {rx_q[6:0], mosi_s};
   assign byte_done = cs_act && sck_rise && (bit_q == 3'd7);
   assign addr_now  = {ahi_q, rx_byte};
   assign rd_addr   = (phase_q == PH_ADDR_LO) ? addr_now : ptr_q;
   assign status_w  = {busy, 2'b00, tsel_q, lock_q};

   assign wr_commit = cs_rise && (bit_q == 3'd0) && (phase_q == PH_WR_DATA) && got_q;
   assign st_commit = cs_rise && (bit_q == 3'd0) && (phase_q == PH_ST_DATA) && got_q;

   spm_wr_timer #(.BUSY_CLKS(BUSY_CLKS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (wr_commit || st_commit),
      .busy_o  (busy),
      .done_o  (tmr_done)
   );

   spm_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit_i    (wr_commit),
      .page_i      (page_q),
      .pbuf_i      (pbuf_q),
      .pvalid_i    (pvalid_q),
      .lock_code_i (lock_q),
      .rd_addr_i   (rd_addr),
      .rd_data_o   (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_CMD;
         bit_q    <= '0;
         rx_q     <= '0;
         is_rd_q  <= 1'b0;
         got_q    <= 1'b0;
         ahi_q    <= '0;
         ptr_q    <= '0;
         page_q   <= '0;
         slot_q   <= '0;
         pbuf_q   <= '0;
         pvalid_q <= '0;
         sdat_q   <= '0;
         tsel_q   <= '0;
         lock_q   <= '0;
         wel_q    <= 1'b0;
         tx_q     <= '0;
         so_q     <= 1'b0;
      end else begin
         if (tmr_done) wel_q <= 1'b0;
         if (st_commit) begin
            tsel_q <= sdat_q[4:3];
            lock_q <= sdat_q[2:0];
         end
         if (!cs_act) begin
            phase_q <= PH_CMD;
            bit_q   <= '0;
            got_q   <= 1'b0;
            tx_q    <= '0;
            so_q    <= 1'b0;
         end else if (sck_rise) begin
            rx_q  <= rx_byte;
            bit_q <= bit_q + 1'b1;
            if (byte_done) begin
               unique case (phase_q)
                  PH_CMD: begin
                     if (busy && rx_byte != CMD_STAT_RD) begin
                        phase_q <= PH_DRAIN;
                     end else begin
                        unique case (rx_byte)
                           CMD_PERMIT: begin
                              wel_q   <= 1'b1;
                              phase_q <= PH_DRAIN;
                           end
                           CMD_REVOKE: begin
                              wel_q   <= 1'b0;
                              phase_q <= PH_DRAIN;
                           end
                           CMD_STAT_RD: begin
                              tx_q    <= status_w;
                              phase_q <= PH_ST_STREAM;
                           end
                           CMD_STAT_WR: phase_q <= wel_q ? PH_ST_DATA : PH_DRAIN;
                           CMD_ARR_WR: begin
                              is_rd_q <= 1'b0;
                              phase_q <= wel_q ? PH_ADDR_HI : PH_DRAIN;
                           end
                           CMD_ARR_RD: begin
                              is_rd_q <= 1'b1;
                              phase_q <= PH_ADDR_HI;
                           end
                           default: phase_q <= PH_DRAIN;
                        endcase
                     end
                  end
                  PH_ADDR_HI: begin
                     ahi_q   <= rx_byte[AHI_W-1:0];
                     phase_q <= PH_ADDR_LO;
                  end
                  PH_ADDR_LO: begin
                     if (is_rd_q) begin
                        tx_q    <= rd_data;
                        ptr_q   <= addr_now + 1'b1;
                        phase_q <= PH_RD_DATA;
                     end else begin
                        page_q   <= addr_now[ADDR_W-1:PAGE_W];
                        slot_q   <= addr_now[PAGE_W-1:0];
                        pvalid_q <= '0;
                        phase_q  <= PH_WR_DATA;
                     end
                  end
                  PH_WR_DATA: begin
                     pbuf_q[{slot_q, 3'b000} +: 8] <= rx_byte;
                     pvalid_q[slot_q]               <= 1'b1;
                     slot_q                         <= slot_q + 1'b1;
                     got_q                          <= 1'b1;
                  end
                  PH_RD_DATA: begin
                     tx_q  <= rd_data;
                     ptr_q <= ptr_q + 1'b1;
                  end
                  PH_ST_DATA: begin
                     if (!got_q) begin
                        sdat_q <= rx_byte[4:0];
                        got_q  <= 1'b1;
                     end else begin
                        phase_q <= PH_DRAIN;
                     end
                  end
                  PH_ST_STREAM: tx_q <= status_w;
                  default: ;
               endcase
            end
         end else if (sck_fall) begin
            so_q <= tx_q[7];
            tx_q <= {tx_q[6:0], 1'b0};
         end
      end
   end

   assign spi_miso = so_q;

   // R3
   wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_commit || st_commit) |-> wel_q);

   // R7
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_commit || st_commit) |-> !busy);

   // R4
   wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_done |=> !wel_q);

   // R13
   so_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && !sck_fall) |=> $stable(so_q));

   // R13
   so_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !so_q);

endmodule

// File: tb/tb_spi_guarded_mem.sv
module tb_spi_guarded_mem;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 5;
   localparam int BUSY       = 200;
   localparam int SETTLE     = BUSY + 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0;
   logic cs_n = 1'b1;
   logic mosi = 1'b0;
   logic miso;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_guarded_mem #(.ADDR_W(10), .PAGE_W(4), .BUSY_CLKS(BUSY), .SYNC_STAGES(2)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_sck  (sck),
      .spi_cs_n (cs_n),
      .spi_mosi (mosi),
      .spi_miso (miso)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic [7:0] m_mem [1024];
   logic [2:0] m_lock = 3'd0;

   function automatic bit m_locked(input logic [2:0] code, input int a);
      case (code)
         3'd1:    return a <= 'h0FF;
         3'd2:    return a >= 'h100 && a <= 'h1FF;
         3'd3:    return a >= 'h200 && a <= 'h2FF;
         3'd4:    return a >= 'h300;
         3'd5:    return a <= 'h1FF;
         3'd6:    return a <= 'h00F;
         3'd7:    return a >= 'h3F0;
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] b, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) begin
         mosi = b[i];
         clks(HALF);
         r[i] = miso;
         sck = 1'b1;
         clks(HALF);
         sck = 1'b0;
      end
   endtask

   task automatic frame_open;
      cs_n = 1'b0;
   endtask

   task automatic frame_close;
      clks(HALF);
      cs_n = 1'b1;
      clks(2*HALF);
   endtask

   task automatic cmd(input logic [7:0] op);
      logic [7:0] r;
      frame_open();
      xfer(op, r);
      frame_close();
   endtask

   task automatic stat_wr(input logic [7:0] v);
      logic [7:0] r;
      frame_open();
      xfer(8'h01, r);
      xfer(v, r);
      frame_close();
   endtask

   task automatic stat_rd(output logic [7:0] v);
      logic [7:0] r;
      frame_open();
      xfer(8'h05, r);
      xfer(8'h00, v);
      frame_close();
   endtask

   task automatic arr_wr(input logic [15:0] a, input int n, input logic [7:0] base, input bit ok);
      logic [7:0] r;
      frame_open();
      xfer(8'h02, r);
      xfer(a[15:8], r);
      xfer(a[7:0], r);
      for (int k = 0; k < n; k++) xfer(8'(base + k), r);
      frame_close();
      if (ok) begin
         for (int k = 0; k < n; k++) begin
            int ad;
            ad = (int'(a[9:0]) & 'h3F0) | ((int'(a[3:0]) + k) & 'hF);
            if (!m_locked(m_lock, ad)) m_mem[ad] = 8'(base + k);
         end
      end
   endtask

   task automatic arr_chk(input logic [15:0] a, input int n, input string req);
      logic [7:0] r;
      frame_open();
      xfer(8'h03, r);
      xfer(a[15:8], r);
      xfer(a[7:0], r);
      for (int k = 0; k < n; k++) begin
         xfer(8'h00, r);
         chk(req, r, m_mem[(int'(a[9:0]) + k) % 1024]);
      end
      frame_close();
   endtask

   int pages [9] = '{0, 1, 15, 16, 31, 32, 47, 48, 63};

   initial begin
      logic [7:0] s;
      logic [7:0] r;
      logic [7:0] poll [5];
      for (int j = 0; j < 1024; j++) m_mem[j] = 8'h00;
      clks(5);
      rst_n = 1'b1;
      clks(5);

      // reset state
      chk("R13 idle output", miso, 0);
      stat_rd(s);
      chk("R1 status after reset", s, 8'h00);
      arr_chk(16'h0000, 2, "R1 array after reset");

      // no permission
      arr_wr(16'h0005, 1, 8'hC3, 1'b0);
      arr_chk(16'h0005, 1, "R3 array write without permission");
      stat_wr(8'h1F);
      stat_rd(s);
      chk("R3 status write without permission", s, 8'h00);

      // permit then revoke
      cmd(8'h06);
      cmd(8'h04);
      arr_wr(16'h0006, 1, 8'h11, 1'b0);
      arr_chk(16'h0006, 1, "R2 revoke blocks write");

      // unknown command leaves permission
      cmd(8'h06);
      cmd(8'hFF);
      arr_wr(16'h0020, 2, 8'hA0, 1'b1);
      clks(SETTLE);
      arr_chk(16'h0020, 2, "R2 unknown command ignored");

      // read wrap across top of array
      cmd(8'h06);
      arr_wr(16'h0000, 1, 8'hA5, 1'b1);
      clks(SETTLE);
      cmd(8'h06);
      arr_wr(16'h03FF, 1, 8'h5A, 1'b1);
      clks(SETTLE);
      arr_chk(16'h03FF, 3, "R12 read wrap");
      arr_chk(16'h0000, 1, "R13 msb first byte");

      // status streaming across busy window
      cmd(8'h06);
      arr_wr(16'h0040, 1, 8'h3C, 1'b1);
      frame_open();
      xfer(8'h05, r);
      for (int k = 0; k < 5; k++) xfer(8'h00, poll[k]);
      frame_close();
      chk("R6 busy visible early", poll[0], 8'h80);
      chk("R6 busy gone late", poll[4], 8'h00);
      clks(SETTLE);
      arr_chk(16'h0040, 1, "R8 single byte write");

      // write during busy ignored
      cmd(8'h06);
      arr_wr(16'h0050, 1, 8'h11, 1'b1);
      arr_wr(16'h0060, 1, 8'h22, 1'b0);
      clks(SETTLE);
      arr_chk(16'h0060, 1, "R7 write during busy");
      arr_chk(16'h0050, 1, "R8 committed byte");

      // permission cleared at end of cycle
      arr_wr(16'h0070, 1, 8'h33, 1'b0);
      arr_chk(16'h0070, 1, "R4 permission auto clear");

      // permit during busy ignored
      cmd(8'h06);
      arr_wr(16'h0071, 1, 8'h66, 1'b1);
      cmd(8'h06);
      clks(SETTLE);
      arr_wr(16'h0072, 1, 8'h44, 1'b0);
      arr_chk(16'h0071, 2, "R7 permit during busy");

      // page wrap, overwrite, high address bits ignored
      cmd(8'h06);
      arr_wr(16'hFC8C, 18, 8'h90, 1'b1);
      clks(SETTLE);
      arr_chk(16'h0080, 16, "R8 page wrap");

      // partial byte aborts
      cmd(8'h06);
      frame_open();
      xfer(8'h02, r);
      xfer(8'h00, r);
      xfer(8'hA0, r);
      xfer(8'h77, r);
      for (int i = 0; i < 3; i++) begin
         mosi = 1'b1;
         clks(HALF);
         sck = 1'b1;
         clks(HALF);
         sck = 1'b0;
      end
      frame_close();
      clks(SETTLE);
      arr_chk(16'h00A0, 1, "R9 partial byte");

      // status field layout
      cmd(8'h06);
      stat_wr(8'hFF);
      clks(SETTLE);
      stat_rd(s);
      chk("R5 upper bits read zero", s, 8'h1F);
      cmd(8'h06);
      frame_open();
      xfer(8'h01, r);
      xfer(8'h0A, r);
      xfer(8'h0C, r);
      frame_close();
      clks(SETTLE);
      stat_rd(s);
      chk("R5 two data bytes discarded", s, 8'h1F);
      cmd(8'h06);
      stat_wr(8'h00);
      clks(SETTLE);
      stat_rd(s);
      chk("R5 status cleared", s, 8'h00);

      // sweep every protection code over boundary pages
      for (int c = 0; c < 8; c++) begin
         logic [7:0] sv;
         sv = {3'b000, 2'(c), 3'(c)};
         cmd(8'h06);
         stat_wr(sv);
         clks(SETTLE);
         m_lock = 3'(c);
         stat_rd(s);
         chk("R5 status readback", s, sv);
         foreach (pages[pi]) begin
            int p;
            logic [7:0] d;
            p = pages[pi];
            d = 8'(c * 37 + p * 3 + 1);
            cmd(8'h06);
            arr_wr(16'(p * 16 + 15), 2, d, 1'b1);
            clks(SETTLE);
            if (m_locked(m_lock, p * 16)) begin
               arr_chk(16'(p * 16), 1, "R10 R11 locked low byte");
               arr_chk(16'(p * 16 + 15), 1, "R10 R11 locked high byte");
            end else begin
               arr_chk(16'(p * 16), 1, "R10 open low byte");
               arr_chk(16'(p * 16 + 15), 1, "R10 open high byte");
            end
         end
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule